// File: doc/BRIEF.md
# Lifecycle transition sequencer

This block is the control state machine that carries a device lifecycle-state transition from request to completion. When it is idle and a request arrives, it walks a fixed chain of steps: clock switch, counter increment, counter programming, transition check and token hashing. An RMA-type request adds a flash wipe. Then come two token comparisons and finally state programming. Each step is carried out by an external helper, which this block starts with a level strobe and which answers with done and error flags. Any failure abandons the chain into a terminal post-transition state with an error flag recorded.

Escalation can force the machine into a sticky escalate state from almost anywhere. It takes one or more independent escalation inputs, which are ORed together. A device already in a scrap lifecycle state is parked in a sticky scrap state, and an invalid lifecycle state is parked in an invalid state. The state register uses a sparse code with a minimum Hamming distance of 3. Any value outside the legal set sends the machine to the invalid state and raises a fatal flag.

Top module: `lcx_ctrl_seq`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the state becomes Reset and `err_o` becomes 0. On the first edge with `rst_ni` high, Reset moves to Idle.
- R2: `state_o` carries the code {i[3:0], i1^i2^i3, i0^i2^i3, i0^i1^i3}, where i is the state index: Reset 1, Idle 2, ClkMux 3, CntIncr 4, CntProg 5, TransCheck 6, TokenHash 7, FlashRma 8, TokenCheck0 9, TokenCheck1 10, TransProg 11, PostTrans 12, Scrap 13, Escalate 14, Invalid 15.
- R3: In Idle, the choice is made in this priority order: escalation, then `lc_invalid_i`, then `lc_scrap_i`, then `req_i`. A request alone moves to ClkMux and captures `req_rma_i`.
- R4: A `step_done_i` pulse on the step's bit advances the chain: ClkMux (bit 0) to CntIncr, CntIncr (bit 1) to CntProg, CntProg (bit 2) to TransCheck, and TransCheck (bit 3) to TokenHash.
- R5: `step_done_i[4]` in TokenHash goes to FlashRma when the captured request was RMA-type, and to TokenCheck0 otherwise.
- R6: `step_err_i[k]` in CntIncr, CntProg, TransCheck, TokenHash or TransProg moves to PostTrans and sets `err_o[0]`. An error takes priority over done. `step_err_i[0]` in ClkMux is ignored.
- R7: In FlashRma, either `step_done_i[5]` or `step_err_i[5]` moves to TokenCheck0, never to PostTrans. An error also sets `err_o[0]`.
- R8: TokenCheck0 moves to TokenCheck1 if `tok_ok_i[0]` is set, and otherwise to PostTrans with `err_o[1]` set. TokenCheck1 always leaves after one cycle: it moves to TransProg if `tok_ok_i` is 2'b11, and otherwise to PostTrans with `err_o[1]` set.
- R9: `step_done_i[6]` in TransProg moves to PostTrans with `err_o` unchanged. PostTrans leaves only for Escalate.
- R10: Idle with `lc_scrap_i` moves to Scrap. Scrap and Escalate are never left before reset, even under escalation.
- R11: With any bit of `esc_i` set, every legal state other than Reset and Scrap moves to Escalate on the next edge.
- R12: Idle with `lc_invalid_i` moves to Invalid and sets `err_o[2]`. Invalid leaves only for Escalate.
- R13: A state register value that is not one of the 15 legal codes moves to Invalid on the next edge and sets `err_o[2]`.
- R14: `step_go_o` has bit k high exactly while the helper of step k is working: 0 ClkMux, 1 CntIncr, 2 CntProg, 3 TransCheck, 4 TokenHash, 5 FlashRma, 6 TransProg. All bits are low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Transition request, sampled in Idle |
| req_rma_i | input | 1 | Request is RMA-type, captured with the request |
| lc_scrap_i | input | 1 | Current lifecycle state is a scrap state |
| lc_invalid_i | input | 1 | Current lifecycle state is invalid |
| esc_i | input | ESC_W | Independent escalation inputs |
| step_done_i | input | 7 | Per-step completion from the helpers |
| step_err_i | input | 7 | Per-step failure from the helpers |
| tok_ok_i | input | 2 | Token comparison results, bit 0 first compare, bit 1 second |
| state_o | output | 7 | Current state in the sparse code |
| step_go_o | output | 7 | Per-step start level |
| err_o | output | 3 | Sticky errors: [0] step, [1] token, [2] fatal |

## Verification
The bench builds the block with the default ESC_W of 2. It drives each escalation input on its own, so each input can be shown to force Escalate without the other's help. The only other constant, the step count, is fixed at seven. This puts both chain variants within reach (with and without the flash wipe), along with each early exit and both token-compare outcomes. An out-of-code value is placed in the state register for one cycle to exercise the illegal-encoding path, which is otherwise unreachable.

// File: rtl/lcx_seq_pkg.sv
// Package: lcx_seq_pkg
// Shared constants for the lifecycle transition sequencer.
// Contents: the sparse state code, the step index map and the error bit positions.
// Assumes: 4-bit state indices are protected by a 7-bit Hamming code,
// which gives a minimum distance of 3 between legal codes.
package lcx_seq_pkg;

    localparam int ST_W      = 7;
    localparam int NUM_STEPS = 7;
    localparam int NUM_ST    = 15;
    localparam int ERR_W     = 3;

    localparam int ERR_STEP  = 0;
    localparam int ERR_TOK   = 1;
    localparam int ERR_FATAL = 2;

    localparam int S_CLK  = 0;
    localparam int S_INC  = 1;
    localparam int S_PROG = 2;
    localparam int S_CHK  = 3;
    localparam int S_HASH = 4;
    localparam int S_WIPE = 5;
    localparam int S_WR   = 6;

    // Maps a 4-bit state index to its 7-bit protected code.
    function automatic logic [ST_W-1:0] st_code(input logic [3:0] d);
        return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
    endfunction

    localparam logic [ST_W-1:0] ST_RESET  = st_code(4'd1);
    localparam logic [ST_W-1:0] ST_IDLE   = st_code(4'd2);
    localparam logic [ST_W-1:0] ST_CLKSW  = st_code(4'd3);
    localparam logic [ST_W-1:0] ST_CINC   = st_code(4'd4);
    localparam logic [ST_W-1:0] ST_CPROG  = st_code(4'd5);
    localparam logic [ST_W-1:0] ST_TCHK   = st_code(4'd6);
    localparam logic [ST_W-1:0] ST_HASH   = st_code(4'd7);
    localparam logic [ST_W-1:0] ST_WIPE   = st_code(4'd8);
    localparam logic [ST_W-1:0] ST_TOK0   = st_code(4'd9);
    localparam logic [ST_W-1:0] ST_TOK1   = st_code(4'd10);
    localparam logic [ST_W-1:0] ST_WRITE  = st_code(4'd11);
    localparam logic [ST_W-1:0] ST_POST   = st_code(4'd12);
    localparam logic [ST_W-1:0] ST_SCRAP  = st_code(4'd13);
    localparam logic [ST_W-1:0] ST_ESC    = st_code(4'd14);
    localparam logic [ST_W-1:0] ST_INV    = st_code(4'd15);

    // The state in which each helper step is running, by step index.
    localparam logic [ST_W-1:0] STEP_ST [NUM_STEPS] =
        '{ST_CLKSW, ST_CINC, ST_CPROG, ST_TCHK, ST_HASH, ST_WIPE, ST_WRITE};

endpackage

// File: rtl/lcx_seq_decode.sv
// Module: lcx_seq_decode
// Decodes the state register.
// Outputs: whether the value is one of the legal codes, and which helper
// step, if any, is running.
// Assumes: legal codes are indices 1..NUM_ST of lcx_seq_pkg::st_code.
module lcx_seq_decode
    import lcx_seq_pkg::*;
(
    input  logic [ST_W-1:0]      state_i,
    output logic                 legal_o,
    output logic [NUM_STEPS-1:0] go_o
);

    logic [NUM_ST-1:0] hit;

    // One comparator per legal code.
    for (genvar i = 0; i < NUM_ST; i++) begin : g_legal
        assign hit[i] = (state_i == st_code(4'(i + 1)));
    end

    // One start level per helper step.
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_go
        assign go_o[k] = (state_i == STEP_ST[k]);
    end

    assign legal_o = |hit;

endmodule

// File: rtl/lcx_seq_next.sv
// Module: lcx_seq_next
// Next-state logic of the transition sequencer.
// Outputs: the next state and the error flags to set on this edge.
// Assumes: legal_i comes from lcx_seq_decode. Inputs are synchronous to
// the sequencer clock.
module lcx_seq_next
    import lcx_seq_pkg::*;
(
    input  logic [ST_W-1:0]      state_i,
    input  logic                 legal_i,
    input  logic                 req_i,
    input  logic                 rma_i,
    input  logic                 scrap_i,
    input  logic                 invalid_i,
    input  logic                 esc_i,
    input  logic [NUM_STEPS-1:0] done_i,
    input  logic [NUM_STEPS-1:0] err_i,
    input  logic [1:0]           tok_ok_i,
    output logic [ST_W-1:0]      next_o,
    output logic [ERR_W-1:0]     set_err_o,
    output logic                 capture_o
);

    logic unused_clk_err;
    assign unused_clk_err = err_i[S_CLK];

    // Transition rules, in priority order: illegal code, escalation, then per state.
    always_comb begin
        next_o    = state_i;
        set_err_o = '0;
        capture_o = 1'b0;
        if (!legal_i) begin
            next_o               = ST_INV;
            set_err_o[ERR_FATAL] = 1'b1;
        end else if (esc_i && state_i != ST_RESET && state_i != ST_SCRAP) begin
            next_o = ST_ESC;
        end else begin
            unique case (state_i)
                ST_RESET: next_o = ST_IDLE;
                ST_IDLE: begin
                    if (invalid_i) begin
                        next_o               = ST_INV;
                        set_err_o[ERR_FATAL] = 1'b1;
                    end else if (scrap_i) begin
                        next_o = ST_SCRAP;
                    end else if (req_i) begin
                        next_o    = ST_CLKSW;
                        capture_o = 1'b1;
                    end
                end
                ST_CLKSW: if (done_i[S_CLK]) next_o = ST_CINC;
                ST_CINC: begin
                    if (err_i[S_INC]) begin
                        next_o              = ST_POST;
                        set_err_o[ERR_STEP] = 1'b1;
                    end else if (done_i[S_INC]) next_o = ST_CPROG;
                end
                ST_CPROG: begin
                    if (err_i[S_PROG]) begin
                        next_o              = ST_POST;
                        set_err_o[ERR_STEP] = 1'b1;
                    end else if (done_i[S_PROG]) next_o = ST_TCHK;
                end
                ST_TCHK: begin
                    if (err_i[S_CHK]) begin
                        next_o              = ST_POST;
                        set_err_o[ERR_STEP] = 1'b1;
                    end else if (done_i[S_CHK]) next_o = ST_HASH;
                end
                ST_HASH: begin
                    if (err_i[S_HASH]) begin
                        next_o              = ST_POST;
                        set_err_o[ERR_STEP] = 1'b1;
                    end else if (done_i[S_HASH]) next_o = rma_i ? ST_WIPE : ST_TOK0;
                end
                ST_WIPE: begin
                    if (err_i[S_WIPE] || done_i[S_WIPE]) next_o = ST_TOK0;
                    set_err_o[ERR_STEP] = err_i[S_WIPE];
                end
                ST_TOK0: begin
                    next_o = tok_ok_i[0] ? ST_TOK1 : ST_POST;
                    set_err_o[ERR_TOK] = !tok_ok_i[0];
                end
                ST_TOK1: begin
                    next_o = (&tok_ok_i) ? ST_WRITE : ST_POST;
                    set_err_o[ERR_TOK] = !(&tok_ok_i);
                end
                ST_WRITE: begin
                    if (err_i[S_WR]) begin
                        next_o              = ST_POST;
                        set_err_o[ERR_STEP] = 1'b1;
                    end else if (done_i[S_WR]) next_o = ST_POST;
                end
                default: next_o = state_i;
            endcase
        end
    end

endmodule

// File: rtl/lcx_ctrl_seq.sv
// Module: lcx_ctrl_seq
// Lifecycle transition sequencer top.
// Holds the sparse-coded state register, the captured RMA flag and the
// sticky error flags.
// Assumes: all inputs are synchronous to clk_i. Helpers hold their done or
// error flag until the state moves on, or pulse it for one cycle.
module lcx_ctrl_seq
    import lcx_seq_pkg::*;
#(
    parameter int ESC_W = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_i,
    input  logic                 req_rma_i,
    input  logic                 lc_scrap_i,
    input  logic                 lc_invalid_i,
    input  logic [ESC_W-1:0]     esc_i,
    input  logic [NUM_STEPS-1:0] step_done_i,
    input  logic [NUM_STEPS-1:0] step_err_i,
    input  logic [1:0]           tok_ok_i,
    output logic [ST_W-1:0]      state_o,
    output logic [NUM_STEPS-1:0] step_go_o,
    output logic [ERR_W-1:0]     err_o
);

    logic [ST_W-1:0]  state_q;
    logic [ST_W-1:0]  state_d;
    logic             rma_q;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_set;
    logic             legal;
    logic             capture;

    lcx_seq_decode u_dec (
        .state_i (state_q),
        .legal_o (legal),
        .go_o    (step_go_o)
    );

    lcx_seq_next u_nxt (
        .state_i   (state_q),
        .legal_i   (legal),
        .req_i     (req_i),
        .rma_i     (rma_q),
        .scrap_i   (lc_scrap_i),
        .invalid_i (lc_invalid_i),
        .esc_i     (|esc_i),
        .done_i    (step_done_i),
        .err_i     (step_err_i),
        .tok_ok_i  (tok_ok_i),
        .next_o    (state_d),
        .set_err_o (err_set),
        .capture_o (capture)
    );

    // State, RMA flag and sticky error registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RESET;
            rma_q   <= 1'b0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | err_set;
            if (capture) rma_q <= req_rma_i;
        end
    end

    assign state_o = state_q;
    assign err_o   = err_q;

endmodule

// File: rtl/lcx_seq_chk.sv
// Module: lcx_seq_chk
// Assertion checker for lcx_ctrl_seq, attached by bind.
// Watches only the top module's ports.
// Assumes: synchronous active-low reset is applied from time zero.
module lcx_seq_chk
    import lcx_seq_pkg::*;
#(
    parameter int ESC_W = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [ESC_W-1:0]     esc_i,
    input logic [ST_W-1:0]      state_o,
    input logic [NUM_STEPS-1:0] step_go_o,
    input logic [ERR_W-1:0]     err_o
);

    // True when the value is one of the legal state codes.
    function automatic logic is_legal(input logic [ST_W-1:0] s);
        logic r = 1'b0;
        for (int i = 1; i <= NUM_ST; i++) r |= (s == st_code(4'(i)));
        return r;
    endfunction

    // R11
    esc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|esc_i) && is_legal(state_o) && state_o != ST_RESET && state_o != ST_SCRAP)
        |=> state_o == ST_ESC);

    // R10
    esc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_ESC |=> state_o == ST_ESC);

    // R10
    scrap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_SCRAP |=> state_o == ST_SCRAP);

    // R9
    post_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_POST |=> (state_o == ST_POST || state_o == ST_ESC));

    // R12
    invalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_INV |=> (state_o == ST_INV || state_o == ST_ESC));

    // R8
    tok1_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_TOK1 |=> state_o != ST_TOK1);

    // R7
    wipe_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == ST_WIPE |=> (state_o == ST_WIPE || state_o == ST_TOK0 || state_o == ST_ESC));

    // R13
    illegal_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_legal(state_o) |=> (state_o == ST_INV && err_o[ERR_FATAL]));

    // R14
    go_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(step_go_o));

endmodule

bind lcx_ctrl_seq lcx_seq_chk #(.ESC_W(ESC_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .esc_i     (esc_i),
    .state_o   (state_o),
    .step_go_o (step_go_o),
    .err_o     (err_o)
);

// File: tb/sim_lcx_ctrl_seq.sv
// Module: sim_lcx_ctrl_seq
// Directed bench for lcx_ctrl_seq.
// Each task runs one scenario and checks its own results.
// Inputs are driven and outputs sampled on the falling clock edge.
module sim_lcx_ctrl_seq;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       req_i = 1'b0, req_rma_i = 1'b0, lc_scrap_i = 1'b0, lc_invalid_i = 1'b0;
    logic [1:0] esc_i = '0;
    logic [6:0] step_done_i = '0, step_err_i = '0;
    logic [1:0] tok_ok_i = '0;
    logic [6:0] state_o;
    logic [6:0] step_go_o;
    logic [2:0] err_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    lcx_ctrl_seq #(.ESC_W(2)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_rma_i(req_rma_i),
        .lc_scrap_i(lc_scrap_i), .lc_invalid_i(lc_invalid_i), .esc_i(esc_i),
        .step_done_i(step_done_i), .step_err_i(step_err_i), .tok_ok_i(tok_ok_i),
        .state_o(state_o), .step_go_o(step_go_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    // Expected code for a state index, as stated in R2.
    function automatic logic [6:0] code(input int i);
        logic [3:0] d = 4'(i);
        return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done(input int k);
        step_done_i[k] = 1'b1;
        tick();
        step_done_i = '0;
    endtask

    task automatic pulse_err(input int k);
        step_err_i[k] = 1'b1;
        tick();
        step_err_i = '0;
    endtask

    task automatic do_reset;
        req_i = 0; req_rma_i = 0; lc_scrap_i = 0; lc_invalid_i = 0;
        esc_i = '0; step_done_i = '0; step_err_i = '0; tok_ok_i = '0;
        rst_ni = 1'b0;
        tick();
        tick();
        chk("R1 R2 reset state", state_o, code(1));
        chk("R1 reset err", err_o, 0);
        rst_ni = 1'b1;
        tick();
        chk("R1 to idle", state_o, code(2));
    endtask

    task automatic start(input logic rma);
        req_i = 1'b1; req_rma_i = rma;
        tick();
        req_i = 1'b0; req_rma_i = 1'b0;
        chk("R3 start", state_o, code(3));
    endtask

    task automatic t_normal;
        do_reset();
        start(1'b0);
        chk("R14 go clksw", step_go_o, 7'h01);
        pulse_err(0);
        chk("R6 clksw err ignored", state_o, code(3));
        pulse_done(0);
        chk("R4 cinc", state_o, code(4));
        chk("R14 go cinc", step_go_o, 7'h02);
        pulse_done(1);
        chk("R4 cprog", state_o, code(5));
        pulse_done(2);
        chk("R4 tchk", state_o, code(6));
        pulse_done(3);
        chk("R4 hash", state_o, code(7));
        pulse_done(4);
        chk("R5 non-rma to tok0", state_o, code(9));
        chk("R14 go none in tok0", step_go_o, 0);
        tok_ok_i = 2'b11;
        tick();
        chk("R8 tok1", state_o, code(10));
        tick();
        chk("R8 tok1 to write", state_o, code(11));
        chk("R14 go write", step_go_o, 7'h40);
        tok_ok_i = 2'b00;
        pulse_done(6);
        chk("R9 post", state_o, code(12));
        chk("R9 clean err", err_o, 0);
        req_i = 1'b1;
        tick();
        tick();
        req_i = 1'b0;
        chk("R9 post terminal", state_o, code(12));
    endtask

    task automatic t_rma;
        do_reset();
        start(1'b1);
        for (int k = 0; k < 4; k++) pulse_done(k);
        pulse_done(4);
        chk("R5 rma to wipe", state_o, code(8));
        chk("R14 go wipe", step_go_o, 7'h20);
        pulse_err(5);
        chk("R7 wipe err to tok0", state_o, code(9));
        chk("R7 wipe err flag", err_o, 3'b001);
        tok_ok_i = 2'b01;
        tick();
        chk("R8 tok0 pass", state_o, code(10));
        tick();
        chk("R8 tok1 mismatch", state_o, code(12));
        chk("R8 tok err flag", err_o, 3'b011);
        tok_ok_i = 2'b00;
    endtask

    task automatic t_step_fail;
        do_reset();
        start(1'b0);
        pulse_done(0);
        pulse_done(1);
        step_done_i[2] = 1'b1;
        pulse_err(2);
        chk("R6 cprog err", state_o, code(12));
        chk("R6 err flag", err_o, 3'b001);
        do_reset();
        start(1'b0);
        for (int k = 0; k < 5; k++) pulse_done(k);
        tok_ok_i = 2'b11;
        tick();
        tick();
        tok_ok_i = 2'b00;
        pulse_err(6);
        chk("R6 write err", state_o, code(12));
        chk("R6 write err flag", err_o, 3'b001);
    endtask

    task automatic t_tok0;
        do_reset();
        start(1'b0);
        for (int k = 0; k < 5; k++) pulse_done(k);
        tok_ok_i = 2'b10;
        tick();
        tok_ok_i = 2'b00;
        chk("R8 tok0 mismatch", state_o, code(12));
        chk("R8 tok0 err flag", err_o, 3'b010);
    endtask

    task automatic t_scrap;
        do_reset();
        lc_scrap_i = 1'b1; req_i = 1'b1;
        tick();
        req_i = 1'b0;
        chk("R10 scrap", state_o, code(13));
        esc_i = 2'b01;
        tick();
        chk("R10 scrap ignores esc", state_o, code(13));
        esc_i = '0; lc_scrap_i = 1'b0;
    endtask

    task automatic t_esc;
        do_reset();
        lc_scrap_i = 1'b1; lc_invalid_i = 1'b1; req_i = 1'b1; esc_i = 2'b10;
        tick();
        chk("R3 R11 esc wins in idle", state_o, code(14));
        lc_scrap_i = 0; lc_invalid_i = 0; req_i = 0; esc_i = '0;
        tick();
        chk("R10 esc sticky", state_o, code(14));
        rst_ni = 1'b0;
        esc_i = 2'b01;
        tick();
        rst_ni = 1'b1;
        tick();
        chk("R11 reset not escalated", state_o, code(2));
        tick();
        chk("R11 esc from idle", state_o, code(14));
        do_reset();
        start(1'b0);
        for (int k = 0; k < 4; k++) pulse_done(k);
        esc_i = 2'b10;
        tick();
        chk("R11 esc from hash", state_o, code(14));
        esc_i = '0;
    endtask

    task automatic t_invalid;
        do_reset();
        lc_invalid_i = 1'b1; lc_scrap_i = 1'b1;
        tick();
        lc_invalid_i = 1'b0; lc_scrap_i = 1'b0;
        chk("R12 R3 invalid", state_o, code(15));
        chk("R12 fatal", err_o, 3'b100);
        req_i = 1'b1;
        tick();
        req_i = 1'b0;
        chk("R12 invalid holds", state_o, code(15));
        esc_i = 2'b01;
        tick();
        esc_i = '0;
        chk("R11 esc from invalid", state_o, code(14));
    endtask

    task automatic t_illegal;
        do_reset();
        start(1'b0);
        pulse_done(0);
        force u0.state_q = code(4) ^ 7'h01;
        #1;
        release u0.state_q;
        tick();
        chk("R13 illegal to invalid", state_o, code(15));
        chk("R13 fatal", err_o, 3'b100);
    endtask

    initial begin
        @(negedge clk);
        t_normal();
        t_rma();
        t_step_fail();
        t_tok0();
        t_scrap();
        t_esc();
        t_invalid();
        t_illegal();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule